// File: doc/BRIEF.md
# MDIO Management Frame Master

This block carries out single register accesses to an Ethernet PHY over the two-wire management interface. A host pulses a start strobe with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then generates the management clock from the system clock through a programmable divider. It serialises a complete frame on the data line, using separate output-value and output-enable signals so that a tri-state pad can sit outside the block.

Each frame is 65 management clock cycles long for both reads and writes. On a read, the master lets go of the data line after the register address and checks the PHY's acknowledge in the second turnaround cycle. It then always clocks through all sixteen data cycles, so the PHY finishes its frame even when the acknowledge is missing. The result, an acknowledge-error flag and a one-cycle completion pulse are presented together when the final idle cycle ends.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, mdc_o, mdio_oe_o, done_o, ack_err_o and rdata_o are all 0.
- R2: While a frame runs, mdc_o is low for DIV system clocks and then high for DIV system clocks in each bit. A frame is exactly 65 such bits and starts with the low half of bit 0 in the system clock after the accepted start. When idle, mdc_o stays low.
- R3: Bits 0 to 31 of a frame form the preamble, with MDIO driven (mdio_oe_o = 1) at 1.
- R4: Bits 32 to 45 carry, each most significant bit first: start pattern 01, opcode (10 = read, 01 = write), the 5-bit PHY address, then the 5-bit register address. All of these bits are driven.
- R5: On a read, mdio_oe_o is 0 from bit 46 until the frame ends. mdio_i is sampled at the rising MDC edge of bit 47. A 0 there is an acknowledge, and a 1 makes ack_err_o read 1 at completion.
- R6: On a read, mdio_i is sampled at the rising MDC edges of bits 48 to 63 and assembled most significant bit first into rdata_o. If the acknowledge failed, the 16 data cycles still run and rdata_o becomes 0.
- R7: On a write, MDIO stays driven through bit 63: bit 46 is 1, bit 47 is 0, and bits 48 to 63 carry write data most significant bit first. After a write, ack_err_o is 0 and rdata_o keeps its previous value.
- R8: Bit 64 is an idle bit with MDIO released. done_o is high for exactly one system clock, the clock after bit 64 ends. rdata_o and ack_err_o hold their new values from that clock on.
- R9: A start strobe while a frame is running has no effect on the frame in progress. A start presented in the done_o cycle is accepted.
- R10: mdio_o and mdio_oe_o change only while mdc_o is low; they are stable throughout every high half of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read result |
| done_o | output | 1 | One-clock completion pulse |
| ack_err_o | output | 1 | Missing acknowledge on last read |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Data line input from the pad |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |

## Verification
The completion pulse of one frame and the acceptance of the next start can fall in the same system clock. The bench holds start high with a new write command from the middle of a read frame, through the done cycle, and drops it only once the model reports the new frame has begun. The reference model must show the ignored part doing nothing and the done-cycle start opening a fresh frame with the new command. The read result and error flag must stay those of the finished read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int IDX_W = 7;
  localparam logic [IDX_W-1:0] BIT_HDR0  = 7'd32;
  localparam logic [IDX_W-1:0] BIT_TA0   = 7'd46;
  localparam logic [IDX_W-1:0] BIT_TA1   = 7'd47;
  localparam logic [IDX_W-1:0] BIT_DLAST = 7'd63;
  localparam logic [IDX_W-1:0] BIT_IDLE  = 7'd64;

  localparam logic [1:0] SOF   = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] TA_WR = 2'b10;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wd;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic bit_end_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc_o     = ph_q;
  assign rise_o    = run_i & wrap & ~ph_q;
  assign bit_end_o = run_i & wrap & ph_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mdio_cmd_t        cmd_i,
  input  logic             bit_end_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_o,
  output logic             fin_o,
  output logic             done_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  mdio_cmd_t        cmd_q;
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      hdr;
  logic [4:0]       pos;
  logic             tx_bit;

  assign load_o = start_i & ~busy_q;
  assign fin_o  = busy_q & bit_end_i & (idx_q == BIT_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cmd_q  <= cmd_i;
      end else if (busy_q && bit_end_i) begin
        if (idx_q == BIT_IDLE) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // frame tail after the preamble, first bit at the MSB
  assign hdr = {SOF, (cmd_q.rd ? OP_RD : OP_WR), cmd_q.phy, cmd_q.regad, TA_WR, cmd_q.wd};
  assign pos = 5'(BIT_DLAST - idx_q);

  always_comb begin
    tx_bit = 1'b1;
    if (idx_q >= BIT_HDR0 && idx_q <= BIT_DLAST) tx_bit = hdr[pos];
  end

  always_comb begin
    mdio_oe_o = 1'b0;
    if (busy_q) mdio_oe_o = cmd_q.rd ? (idx_q < BIT_TA0) : (idx_q < BIT_IDLE);
  end

  assign mdio_o = mdio_oe_o ? tx_bit : 1'b1;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign rd_o   = cmd_q.rd;
  assign done_o = done_q;
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fin_i,
  input  logic             rd_i,
  input  logic             mdio_i,
  output logic [15:0]      rdata_o,
  output logic             ack_err_o
);
  logic [15:0] sh_q;
  logic        ack_q;
  logic [15:0] rdata_q;
  logic        err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (sample_i) begin
        if (idx_i == BIT_TA1) ack_q <= ~mdio_i;
        if (idx_i > BIT_TA1 && idx_i <= BIT_DLAST) sh_q <= {sh_q[14:0], mdio_i};
      end
      if (fin_i) begin
        if (rd_i) begin
          rdata_q <= ack_q ? sh_q : 16'h0000;
          err_q   <= ~ack_q;
        end else begin
          err_q   <= 1'b0;
        end
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign ack_err_o = err_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        done_o,
  output logic        ack_err_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  mdio_cmd_t        cmd;
  logic             load, busy, rise, bit_end, fin, rd_cur;
  logic [IDX_W-1:0] idx;

  assign cmd = '{rd: rd_i, phy: phy_addr_i, regad: reg_addr_i, wd: wdata_i};

  mdio_clk_div #(.DIV(DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (busy),
    .mdc_o     (mdc_o),
    .rise_o    (rise),
    .bit_end_o (bit_end)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmd_i     (cmd),
    .bit_end_i (bit_end),
    .load_o    (load),
    .busy_o    (busy),
    .idx_o     (idx),
    .rd_o      (rd_cur),
    .fin_o     (fin),
    .done_o    (done_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  mdio_rx_capture u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (rise & busy & rd_cur),
    .idx_i     (idx),
    .fin_i     (fin),
    .rd_i      (rd_cur),
    .mdio_i    (mdio_i),
    .rdata_o   (rdata_o),
    .ack_err_o (ack_err_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        done_o,
  input logic        ack_err_o,
  input logic [15:0] rdata_o
);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mdio_oe_o && !mdc_o));

  a_r10_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r6_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ack_err_o) |-> (rdata_o == 16'h0000));

  a_r8_result_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$rose(done_o)) |-> ($stable(rdata_o) && $stable(ack_err_o)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .done_o    (done_o),
  .ack_err_o (ack_err_o),
  .rdata_o   (rdata_o)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int FRAME_CYC  = 65 * 2 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        mdio_i = 1'b1;
  logic [15:0] rdata_o;
  logic        done_o, ack_err_o, mdc_o, mdio_o, mdio_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int          k = -1;
  bit          m_done = 0;
  bit          m_rd = 0;
  bit          poked = 0;
  bit          tx_q[$];
  bit          rsp_ack = 1;
  logic [15:0] rsp_data = '0;
  logic [15:0] exp_rdata = '0;
  bit          exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .done_o(done_o), .ack_err_o(ack_err_o),
    .mdc_o(mdc_o), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (k=%0d)", req, what, act, exp, k);
    end
  endtask

  task automatic build_frame();
    tx_q.delete();
    repeat (32) tx_q.push_back(1'b1);
    tx_q.push_back(1'b0); tx_q.push_back(1'b1);
    if (m_rd) begin tx_q.push_back(1'b1); tx_q.push_back(1'b0); end
    else      begin tx_q.push_back(1'b0); tx_q.push_back(1'b1); end
    for (int i = 4; i >= 0; i--) tx_q.push_back(phy_addr_i[i]);
    for (int i = 4; i >= 0; i--) tx_q.push_back(reg_addr_i[i]);
    if (!m_rd) begin
      tx_q.push_back(1'b1); tx_q.push_back(1'b0);
      for (int i = 15; i >= 0; i--) tx_q.push_back(wdata_i[i]);
    end
  endtask

  // one system clock: drive PHY, compare, advance the model across the edge
  task automatic step();
    int  bitn;
    bit  ph, e_mdc, e_oe;
    string tg;
    bitn = (k >= 0) ? k / (2*DIV) : 0;
    ph   = (k >= 0) && ((k % (2*DIV)) >= DIV);
    mdio_i = 1'b1;
    if (k >= 0 && m_rd) begin
      if (bitn == 47) mdio_i = rsp_ack ? 1'b0 : 1'b1;
      else if (bitn >= 48 && bitn <= 63) mdio_i = rsp_data[63 - bitn];
    end
    e_mdc = ph;
    e_oe  = (k >= 0) && (m_rd ? (bitn < 46) : (bitn < 64));
    #1;
    chk(mdc_o == e_mdc, "R2", "mdc_o", mdc_o, e_mdc);
    chk(mdio_oe_o == e_oe, m_rd ? "R5" : "R7", "mdio_oe_o", mdio_oe_o, e_oe);
    if (e_oe) begin
      if (poked)            tg = "R9";
      else if (bitn < 32)   tg = "R3";
      else if (bitn < 46)   tg = "R4";
      else                  tg = "R7";
      chk(mdio_o == tx_q[bitn], tg, "mdio_o", mdio_o, tx_q[bitn]);
    end
    chk(done_o == m_done, "R8", "done_o", done_o, m_done);
    if (m_done) begin
      chk(rdata_o == exp_rdata, "R6", "rdata_o", rdata_o, exp_rdata);
      chk(ack_err_o == exp_err, "R5", "ack_err_o", ack_err_o, exp_err);
    end
    @(posedge clk);
    if (k >= 0) begin
      m_done = 0;
      if (start_i) poked = 1;
      if (k == FRAME_CYC - 1) begin
        k = -1;
        m_done = 1;
        poked = 0;
        if (m_rd) begin
          exp_rdata = rsp_ack ? rsp_data : 16'h0000;
          exp_err   = !rsp_ack;
        end else begin
          exp_err = 0;
        end
      end else begin
        k++;
      end
    end else begin
      m_done = 0;
      if (start_i) begin
        k = 0;
        m_rd = rd_i;
        build_frame();
      end
    end
    @(negedge clk);
  endtask

  task automatic set_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd);
    rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
  endtask

  task automatic run(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input bit ack, input logic [15:0] pd);
    rsp_ack = ack; rsp_data = pd;
    set_cmd(rd, pa, ra, wd);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    while (k >= 0) step();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mdc_o == 1'b0, "R1", "mdc_o", mdc_o, 0);
    chk(mdio_oe_o == 1'b0, "R1", "mdio_oe_o", mdio_oe_o, 0);
    chk(done_o == 1'b0, "R1", "done_o", done_o, 0);
    chk(rdata_o == 16'h0, "R1", "rdata_o", rdata_o, 0);
    chk(ack_err_o == 1'b0, "R1", "ack_err_o", ack_err_o, 0);
    repeat (3) step();

    // R7 write frame
    run(1'b0, 5'h11, 5'h0A, 16'hA5C3, 1'b1, 16'h0);
    // R5 R6 read with acknowledge, edge bits set
    run(1'b1, 5'h1F, 5'h1F, 16'h0, 1'b1, 16'h8001);
    // R7 write leaves rdata_o alone
    run(1'b0, 5'h00, 5'h00, 16'hFFFF, 1'b1, 16'h0);
    chk(rdata_o == 16'h8001, "R7", "rdata_o kept", rdata_o, 16'h8001);
    // R6 failed acknowledge returns zero, still full length
    run(1'b1, 5'h05, 5'h12, 16'h0, 1'b0, 16'hFFFF);
    chk(ack_err_o == 1'b1, "R5", "ack_err_o held", ack_err_o, 1);
    // R7 write clears the error
    run(1'b0, 5'h0A, 5'h15, 16'h1234, 1'b1, 16'h0);
    chk(ack_err_o == 1'b0, "R7", "ack_err_o cleared", ack_err_o, 0);

    // R9 start held from mid-read through the done cycle
    rsp_ack = 1; rsp_data = 16'h3C5A;
    set_cmd(1'b1, 5'h03, 5'h01, 16'h0);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (FRAME_CYC / 2) step();
    set_cmd(1'b0, 5'h1C, 5'h07, 16'h0F0F);
    start_i = 1'b1;
    while (k != 0) step();
    start_i = 1'b0;
    chk(exp_rdata == 16'h3C5A && rdata_o == 16'h3C5A, "R9", "rdata_o at restart", rdata_o, 16'h3C5A);
    while (k >= 0) step();
    step();
    repeat (5) step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule